// File: doc/BRIEF.md
# Branch Hazard Fetch Stall Controller

This block steers instruction fetch for an in-order pipeline whose depth is a parameter. Each cycle it presents a fetch address, and the instruction memory answers in the same cycle with a decoded class for that address (plain instruction, unconditional jump or conditional branch) and its target. Once a jump or branch is fetched, the block lets fetch take exactly one more instruction, the sequential successor, and holds it in the fetch stage. It then waits until the control transfer reaches its resolve stage. Jumps resolve at stage `JUMP_RESOLVE` and conditional branches at stage `BR_RESOLVE`.

At resolution the held successor is dropped and fetch restarts at the target, for a jump or a taken branch. For a not-taken branch the successor is released into decode without being fetched again. Empty decode slots travel down a valid-bit shadow of the pipeline as bubbles. The block keeps two saturating counters so that CPI can be read off: one counts cycles in which nothing entered decode, the other counts instructions that reached the last stage. These are the per-class costs:

- a jump costs `JUMP_RESOLVE-1` stall cycles
- a taken branch costs `BR_RESOLVE-1` stall cycles
- a not-taken branch costs `BR_RESOLVE-2` stall cycles

All pins are plain control signals. Fetch timing is fixed by the block itself, so there is no valid/ready handshake and no back-pressure from either side. The outcome of a conditional branch is read on `br_taken` only in the cycle in which `br_resolve` is high.

Top module: `bhfc_top`

## Requirements
- R1: After synchronous reset the fetch address is 0, both counters read 0, and fetch fires at address 0 in the first cycle after reset.
- R2: A fetched instruction of class 0 or 3 (plain) is followed by a fetch of address+1 in the next cycle, with no stall.
- R3: A jump (class 1) fetched in cycle t has its successor fetched in t+1 and squashed in cycle t+JUMP_RESOLVE-1. Its target is fetched in cycle t+JUMP_RESOLVE.
- R4: A conditional branch (class 2) fetched in cycle t raises `br_resolve` in cycle t+BR_RESOLVE-1 and samples `br_taken` there. If taken, the successor is squashed in that cycle and the target is fetched in cycle t+BR_RESOLVE.
- R5: If that branch is not taken, its successor enters decode without being fetched again, and the next new fetch happens in cycle t+BR_RESOLVE.
- R6: While a jump or branch is unresolved, fetch fires only for the one successor, `fetch_hold` is high in every other cycle, and the fetch address does not move except at a redirect.
- R7: A released successor that is itself a jump or branch starts its own resolution at once: its own successor is fetched in the next cycle.
- R8: A squash is followed by `dec_valid`=0 in the next cycle. `retire_count` counts only valid instructions, and one that left fetch in cycle s is counted from cycle s+DEPTH on.
- R9: `stall_count` increments once for every cycle in which no instruction leaves fetch for decode.
- R10: Both counters stop at 2^CNT_W-1 and do not wrap.
- R11: `pc_sel` reads 2 (target) in a squash cycle, 0 (sequential) in any other cycle that fires a fetch, and 1 (hold) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| if_kind | input | 2 | Class of the instruction at `fetch_pc`: 0/3 plain, 1 jump, 2 branch |
| if_target | input | PC_W | Target of the instruction at `fetch_pc` |
| br_taken | input | 1 | Branch outcome, sampled while `br_resolve` is high |
| fetch_pc | output | PC_W | Address being fetched |
| fetch_fire | output | 1 | A fetch is launched this cycle |
| fetch_hold | output | 1 | Fetch is held this cycle |
| pc_sel | output | 2 | Next-address choice: 0 sequential, 1 hold, 2 target |
| br_resolve | output | 1 | A conditional branch is in its resolve stage |
| squash | output | 1 | The held successor is discarded this cycle |
| dec_valid | output | 1 | Decode stage holds a valid instruction (0 = bubble) |
| retire_valid | output | 1 | Last stage holds a valid instruction |
| stall_count | output | CNT_W | Saturating count of stall cycles |
| retire_count | output | CNT_W | Saturating count of retired instructions |

## Verification
The bench builds two instances side by side. One is a 4-stage pipeline with jumps resolving at stage 2 and branches at stage 3. This brings in the case where a jump resolves in the very cycle its successor is fetched. The other is a 15-stage pipeline resolving at stages 5 and 10, where long holds and back-to-back released branches show up. Both use 10-bit counters, so the stall counter of the deep pipeline and the retire counter of the shallow one both reach saturation within one run.

// File: rtl/bhfc_pkg.sv
package bhfc_pkg;

  typedef enum logic [1:0] {
    K_PLAIN  = 2'd0,
    K_JUMP   = 2'd1,
    K_BRANCH = 2'd2,
    K_PLAIN2 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_REDIR = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_HOLD = 2'd1,
    SEL_TGT  = 2'd2
  } pc_sel_e;

  function automatic logic is_xfer(input logic [1:0] k);
    return (k == K_JUMP) || (k == K_BRANCH);
  endfunction

endpackage

// File: rtl/bhfc_sat_counter.sv
module bhfc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (inc && (q != TOP))
      q <= q + 1'b1;
  end

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (q == TOP) |=> (q == TOP));

  assert_sat_step_R9: assert property (@(posedge clk) disable iff (rst)
    (inc && (q != TOP)) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/bhfc_valid_pipe.sv
module bhfc_valid_pipe #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic first_valid,
  output logic last_valid
);
  logic [STAGES-1:0] v;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v[i] <= 1'b0;
        else     v[i] <= in_valid;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v[i] <= 1'b0;
        else     v[i] <= v[i-1];
      end
    end
  end

  assign first_valid = v[0];
  assign last_valid  = v[STAGES-1];

endmodule

// File: rtl/bhfc_ctrl.sv
module bhfc_ctrl
  import bhfc_pkg::*;
#(
  parameter int PC_W         = 16,
  parameter int JUMP_RESOLVE = 2,
  parameter int BR_RESOLVE   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      if_kind,
  input  logic [PC_W-1:0] if_target,
  input  logic            br_taken,
  output logic [PC_W-1:0] fetch_pc,
  output logic            fetch_fire,
  output logic [1:0]      pc_sel,
  output logic            br_resolve,
  output logic            squash,
  output logic            issue
);
  localparam int CW = $clog2(BR_RESOLVE + 1);
  localparam logic [CW-1:0] J_AT = CW'(JUMP_RESOLVE - 1);
  localparam logic [CW-1:0] B_AT = CW'(BR_RESOLVE - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  ctl_state_e      st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [PC_W-1:0] pc, pc_n;
  logic            cur_jump, cur_jump_n;
  logic [PC_W-1:0] cur_tgt, cur_tgt_n;
  logic            held_xfer, held_xfer_n;
  logic            held_jump, held_jump_n;
  logic [PC_W-1:0] held_tgt, held_tgt_n;

  logic            succ_xfer, succ_jump;
  logic [PC_W-1:0] succ_tgt;
  logic [CW-1:0]   resolve_at;
  pc_sel_e         sel;

  // the successor is either arriving now (resolve in its fetch cycle) or held
  assign succ_xfer  = (cnt == ONE) ? is_xfer(if_kind)     : held_xfer;
  assign succ_jump  = (cnt == ONE) ? (if_kind == K_JUMP)  : held_jump;
  assign succ_tgt   = (cnt == ONE) ? if_target            : held_tgt;
  assign resolve_at = cur_jump ? J_AT : B_AT;

  always_comb begin
    st_n        = st;
    cnt_n       = cnt;
    pc_n        = pc;
    cur_jump_n  = cur_jump;
    cur_tgt_n   = cur_tgt;
    held_xfer_n = held_xfer;
    held_jump_n = held_jump;
    held_tgt_n  = held_tgt;
    fetch_fire  = 1'b0;
    sel         = SEL_HOLD;
    br_resolve  = 1'b0;
    squash      = 1'b0;
    issue       = 1'b0;
    unique case (st)
      ST_IDLE, ST_REDIR: begin
        fetch_fire = 1'b1;
        issue      = 1'b1;
        pc_n       = pc + PC_W'(1);
        sel        = SEL_SEQ;
        st_n       = ST_IDLE;
        if (is_xfer(if_kind)) begin
          st_n       = ST_WAIT;
          cnt_n      = ONE;
          cur_jump_n = (if_kind == K_JUMP);
          cur_tgt_n  = if_target;
        end
      end
      ST_WAIT: begin
        if (cnt == ONE) begin
          fetch_fire  = 1'b1;
          pc_n        = pc + PC_W'(1);
          sel         = SEL_SEQ;
          held_xfer_n = is_xfer(if_kind);
          held_jump_n = (if_kind == K_JUMP);
          held_tgt_n  = if_target;
        end
        if (cnt == resolve_at) begin
          br_resolve = !cur_jump;
          if (cur_jump || br_taken) begin
            squash = 1'b1;
            pc_n   = cur_tgt;
            sel    = SEL_TGT;
            st_n   = ST_REDIR;
          end else begin
            issue = 1'b1;
            st_n  = ST_IDLE;
            if (succ_xfer) begin
              st_n       = ST_WAIT;
              cnt_n      = ONE;
              cur_jump_n = succ_jump;
              cur_tgt_n  = succ_tgt;
            end
          end
        end else begin
          cnt_n = cnt + ONE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      pc        <= '0;
      cur_jump  <= 1'b0;
      cur_tgt   <= '0;
      held_xfer <= 1'b0;
      held_jump <= 1'b0;
      held_tgt  <= '0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      pc        <= pc_n;
      cur_jump  <= cur_jump_n;
      cur_tgt   <= cur_tgt_n;
      held_xfer <= held_xfer_n;
      held_jump <= held_jump_n;
      held_tgt  <= held_tgt_n;
    end
  end

  assign fetch_pc = pc;
  assign pc_sel   = sel;

  assert_redirect_fires_R3: assert property (@(posedge clk) disable iff (rst)
    squash |=> fetch_fire);

  assert_hold_keeps_pc_R6: assert property (@(posedge clk) disable iff (rst)
    !fetch_fire |=> ($stable(fetch_pc) || $past(squash)));

  assert_not_taken_resumes_R5: assert property (@(posedge clk) disable iff (rst)
    (br_resolve && !br_taken) |=> fetch_fire);

endmodule

// File: rtl/bhfc_top.sv
module bhfc_top #(
  parameter int PC_W         = 16,
  parameter int DEPTH        = 4,
  parameter int JUMP_RESOLVE = 2,
  parameter int BR_RESOLVE   = 3,
  parameter int CNT_W        = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       if_kind,
  input  logic [PC_W-1:0]  if_target,
  input  logic             br_taken,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_fire,
  output logic             fetch_hold,
  output logic [1:0]       pc_sel,
  output logic             br_resolve,
  output logic             squash,
  output logic             dec_valid,
  output logic             retire_valid,
  output logic [CNT_W-1:0] stall_count,
  output logic [CNT_W-1:0] retire_count
);
  localparam int SHADOW = DEPTH - 1;

  logic issue;

  bhfc_ctrl #(
    .PC_W(PC_W), .JUMP_RESOLVE(JUMP_RESOLVE), .BR_RESOLVE(BR_RESOLVE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .if_kind(if_kind), .if_target(if_target), .br_taken(br_taken),
    .fetch_pc(fetch_pc), .fetch_fire(fetch_fire), .pc_sel(pc_sel),
    .br_resolve(br_resolve), .squash(squash), .issue(issue)
  );

  assign fetch_hold = !fetch_fire;

  bhfc_valid_pipe #(.STAGES(SHADOW)) u_pipe (
    .clk(clk), .rst(rst), .in_valid(issue),
    .first_valid(dec_valid), .last_valid(retire_valid)
  );

  bhfc_sat_counter #(.W(CNT_W)) u_stalls (
    .clk(clk), .rst(rst), .inc(!issue), .q(stall_count)
  );

  bhfc_sat_counter #(.W(CNT_W)) u_retired (
    .clk(clk), .rst(rst), .inc(retire_valid), .q(retire_count)
  );

  assert_bubble_after_squash_R8: assert property (@(posedge clk) disable iff (rst)
    squash |=> !dec_valid);

endmodule

// File: tb/sim_bhfc_top.sv
module sim_bhfc_top;
  localparam int PCW  = 16;
  localparam int CW   = 10;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NINS = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10ns clk = ~clk;

  logic [PCW-1:0] pc_o[2];
  logic [PCW-1:0] tg_i[2];
  logic [1:0]     kind_i[2];
  logic [1:0]     sel_o[2];
  logic [CW-1:0]  stall_o[2], ret_o[2];
  logic fire_o[2], hold_o[2], res_o[2], sq_o[2], dec_o[2], rv_o[2];
  logic tk_i[2];

  int nchk = 0, nbad = 0;

  int    ipc[2][$];
  int    icyc[2][$];
  int    iidx[2][$];
  string ireq[2][$];
  int    sqq[2][$];
  bit    tkq[2][$];
  int    iss[2][$];

  function automatic logic [31:0] hash(input logic [PCW-1:0] p);
    return {16'h0, p} * 32'h9E3779B1;
  endfunction
  function automatic logic [1:0] kind_of(input logic [PCW-1:0] p);
    logic [3:0] h;
    h = hash(p)[31:28];
    if (h < 4'd9)        return 2'd0;
    else if (h == 4'd9)  return 2'd3;
    else if (h < 4'd12)  return 2'd1;
    else                 return 2'd2;
  endfunction
  function automatic logic [PCW-1:0] tgt_of(input logic [PCW-1:0] p);
    return {8'h0, hash(p)[15:8]};
  endfunction

  assign kind_i[0] = kind_of(pc_o[0]);
  assign kind_i[1] = kind_of(pc_o[1]);
  assign tg_i[0]   = tgt_of(pc_o[0]);
  assign tg_i[1]   = tgt_of(pc_o[1]);

  bhfc_top #(.PC_W(PCW), .DEPTH(4), .JUMP_RESOLVE(2), .BR_RESOLVE(3), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .if_kind(kind_i[0]), .if_target(tg_i[0]), .br_taken(tk_i[0]),
    .fetch_pc(pc_o[0]), .fetch_fire(fire_o[0]), .fetch_hold(hold_o[0]), .pc_sel(sel_o[0]),
    .br_resolve(res_o[0]), .squash(sq_o[0]), .dec_valid(dec_o[0]), .retire_valid(rv_o[0]),
    .stall_count(stall_o[0]), .retire_count(ret_o[0]));

  bhfc_top #(.PC_W(PCW), .DEPTH(15), .JUMP_RESOLVE(5), .BR_RESOLVE(10), .CNT_W(CW)) u1 (
    .clk(clk), .rst(rst), .if_kind(kind_i[1]), .if_target(tg_i[1]), .br_taken(tk_i[1]),
    .fetch_pc(pc_o[1]), .fetch_fire(fire_o[1]), .fetch_hold(hold_o[1]), .pc_sel(sel_o[1]),
    .br_resolve(res_o[1]), .squash(sq_o[1]), .dec_valid(dec_o[1]), .retire_valid(rv_o[1]),
    .stall_count(stall_o[1]), .retire_count(ret_o[1]));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_fetch(input int w, input int p, input int c, input int i, input string r);
    ipc[w].push_back(p); icyc[w].push_back(c); iidx[w].push_back(i); ireq[w].push_back(r);
  endtask

  // driver: reference model of fetch order, timing and squashes
  task automatic gen(input int w, input int jr, input int br, input int n);
    int p = 0, t = 0;
    bit pre = 1'b0;
    string why = "R1";
    for (int i = 0; i < n; i++) begin
      logic [1:0] k;
      if (!pre) push_fetch(w, p, t, i, why);
      iss[w].push_back(t);
      k = kind_of(PCW'(p));
      if (k == 2'd1) begin
        push_fetch(w, (p + 1) & 16'hFFFF, t + 1, -1, "R3");
        sqq[w].push_back(t + jr - 1);
        p = int'(tgt_of(PCW'(p))); t += jr; pre = 1'b0; why = "R3";
      end else if (k == 2'd2) begin
        bit tk;
        tk = 1'($urandom_range(1, 0));
        tkq[w].push_back(tk);
        push_fetch(w, (p + 1) & 16'hFFFF, t + 1, -1, pre ? "R7" : "R6");
        if (tk) begin
          sqq[w].push_back(t + br - 1);
          p = int'(tgt_of(PCW'(p))); t += br; pre = 1'b0; why = "R4";
        end else begin
          p = (p + 1) & 16'hFFFF; t += br - 1; pre = 1'b1; why = "R5";
        end
      end else begin
        p = (p + 1) & 16'hFFFF; t += 1; pre = 1'b0; why = "R2";
      end
    end
  endtask

  // monitor: pops expected items as the design produces them
  task automatic mon(input int w);
    int t = 0, rp = 0;
    int dep = (w == 0) ? 4 : 15;
    bit sq_prev = 1'b0;
    while ((ipc[w].size() > 0 || sqq[w].size() > 0) && t < 60000) begin
      #1ns;
      if (res_o[w]) begin
        chk(tkq[w].size() > 0, "R4", "unexpected br_resolve", 1, 0);
        if (tkq[w].size() > 0) tk_i[w] = tkq[w].pop_front();
      end
      #1ns;
      if (t == 0) begin
        chk(pc_o[w] == 0, "R1", "fetch_pc after reset", int'(pc_o[w]), 0);
        chk(stall_o[w] == 0, "R1", "stall_count after reset", int'(stall_o[w]), 0);
        chk(ret_o[w] == 0, "R1", "retire_count after reset", int'(ret_o[w]), 0);
        chk(fire_o[w] == 1'b1, "R1", "first fetch fires", int'(fire_o[w]), 1);
      end
      if (sq_prev) chk(dec_o[w] == 1'b0, "R8", "bubble after squash", int'(dec_o[w]), 0);
      chk(int'(sel_o[w]) == (sq_o[w] ? 2 : (fire_o[w] ? 0 : 1)), "R11", "pc_sel",
          int'(sel_o[w]), sq_o[w] ? 2 : (fire_o[w] ? 0 : 1));
      if (!fire_o[w]) chk(hold_o[w] == 1'b1, "R6", "hold while idle fetch", int'(hold_o[w]), 1);
      if (fire_o[w]) begin
        if (ipc[w].size() == 0) begin
          chk(1'b0, "R6", "fetch beyond model", t, -1);
        end else begin
          int ep = ipc[w].pop_front();
          int ec = icyc[w].pop_front();
          int ei = iidx[w].pop_front();
          string er = ireq[w].pop_front();
          chk(int'(pc_o[w]) == ep, er, "fetch address", int'(pc_o[w]), ep);
          chk(t == ec, er, "fetch cycle", t, ec);
          if (ei >= 0) begin
            int es = (t - ei > MAXC) ? MAXC : t - ei;
            int er2;
            while (rp < iss[w].size() && iss[w][rp] <= t - dep) rp++;
            er2 = (rp > MAXC) ? MAXC : rp;
            chk(int'(stall_o[w]) == es, (es == MAXC) ? "R10" : "R9", "stall_count",
                int'(stall_o[w]), es);
            chk(int'(ret_o[w]) == er2, (er2 == MAXC) ? "R10" : "R8", "retire_count",
                int'(ret_o[w]), er2);
          end
        end
      end
      if (sq_o[w]) begin
        if (sqq[w].size() == 0) chk(1'b0, "R4", "unexpected squash", t, -1);
        else begin
          int es = sqq[w].pop_front();
          chk(t == es, "R3", "squash cycle (jump or taken R4)", t, es);
        end
      end
      sq_prev = sq_o[w];
      @(negedge clk);
      t++;
    end
    chk(ipc[w].size() == 0 && sqq[w].size() == 0, "R6", "model drained",
        ipc[w].size() + sqq[w].size(), 0);
  endtask

  initial begin
    tk_i[0] = 1'b0;
    tk_i[1] = 1'b0;
    gen(0, 2, 3, NINS);
    gen(1, 5, 10, NINS);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      mon(0);
      mon(1);
    join
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

endmodule